// File: doc/BRIEF.md
# Gyro Heading Offset Corrector

This block cleans up the digital heading word delivered by a gyro compass before it is used to turn relative bearings into true bearings. Each cycle it takes a heading word and a platform-specific offset word, and either adds the offset to the heading or subtracts it. A single direction-select pin makes that choice. The heading is an angle on a full circle: the full range of the word spans 360 degrees. Every sum or difference therefore wraps around the circle and never saturates.

The corrected heading is registered and appears one clock after the inputs are sampled. Alongside it, a qualifier flag reports whether the registered result lies inside an acceptance window. The window is set at build time by two inclusive bounds. Heading, offset and direction-select are plain level inputs and are sampled on every rising clock edge. There is no handshake: the downstream logic reads the registered pair whenever it needs it.

Top module: `gyro_hdg_corr`

## Requirements
- R1: While `rst_n` is low, `hdg_out` is 0 and `hdg_ok` is 0. Reset is asynchronous and active low.
- R2: When `sub_sel` is 0 at a rising edge, `hdg_out` after that edge equals (`hdg_in` + `ofs_in`) modulo 2^HDG_W.
- R3: When `sub_sel` is 1 at a rising edge, `hdg_out` after that edge equals (`hdg_in` − `ofs_in`) modulo 2^HDG_W.
- R4: A sum past the top of the circle wraps to a small value, and a difference below zero wraps to a large value. There is no saturation. For example, 4090+10 gives 4, and 5−10 gives 4091.
- R5: `hdg_ok` is 1 exactly when the registered `hdg_out` satisfies RANGE_MIN ≤ `hdg_out` ≤ RANGE_MAX. It changes in the same cycle as `hdg_out`. The defaults are RANGE_MIN=16 and RANGE_MAX=4079.
- R6: Both window bounds are inclusive. With the defaults, 16 and 4079 give `hdg_ok`=1, and 15 and 4080 give `hdg_ok`=0.
- R7: Latency is exactly one clock. The outputs keep their previous value until the next rising edge after an input change, and then update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdg_in | input | HDG_W | Raw heading from the compass |
| ofs_in | input | HDG_W | Platform offset to remove |
| sub_sel | input | 1 | 0: add offset, 1: subtract offset |
| hdg_out | output | HDG_W | Registered corrected heading |
| hdg_ok | output | 1 | Result lies inside the acceptance window |

## Verification
Circle wrap-around and the window boundary check can act on the same result. This happens when a wrapped sum or difference lands exactly on RANGE_MIN or RANGE_MAX. The bench provokes both cases: 4090+22 wraps to 16, and 10−27 wraps to 4079. It expects the boundary value on `hdg_out` together with `hdg_ok`=1. It also checks the neighbours one count outside the window, which must clear the flag.

// File: rtl/gyro_hdg_pkg.sv
package gyro_hdg_pkg;
  typedef enum logic {CORR_ADD = 1'b0, CORR_SUB = 1'b1} corr_dir_e;
endpackage

// File: rtl/hdg_offset_alu.sv
module hdg_offset_alu #(
  parameter int HDG_W = 12
) (
  input  logic [HDG_W-1:0]       hdg,
  input  logic [HDG_W-1:0]       ofs,
  input  gyro_hdg_pkg::corr_dir_e dir,
  output logic [HDG_W-1:0]       res
);
  // Two's-complement negate the offset for subtraction; dropping the carry
  // gives wrap-around on the circle for both directions.
  logic [HDG_W-1:0] ofs_eff;
  always_comb begin
    ofs_eff = (dir == gyro_hdg_pkg::CORR_SUB) ? (~ofs + HDG_W'(1)) : ofs;
    res     = hdg + ofs_eff;
  end
endmodule

// File: rtl/hdg_window_cmp.sv
module hdg_window_cmp #(
  parameter int HDG_W     = 12,
  parameter int RANGE_MIN = 16,
  parameter int RANGE_MAX = 4079
) (
  input  logic [HDG_W-1:0] val,
  output logic             in_win
);
  localparam logic [HDG_W-1:0] LO = HDG_W'(RANGE_MIN);
  localparam logic [HDG_W-1:0] HI = HDG_W'(RANGE_MAX);
  always_comb in_win = (val >= LO) && (val <= HI);
endmodule

// File: rtl/hdg_out_reg.sv
module hdg_out_reg #(
  parameter int HDG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HDG_W-1:0] d_val,
  input  logic             d_ok,
  output logic [HDG_W-1:0] q_val,
  output logic             q_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_val <= '0;
      q_ok  <= 1'b0;
    end else begin
      q_val <= d_val;
      q_ok  <= d_ok;
    end
  end
endmodule

// File: rtl/gyro_hdg_corr.sv
module gyro_hdg_corr #(
  parameter int HDG_W     = 12,
  parameter int RANGE_MIN = 16,
  parameter int RANGE_MAX = 4079
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HDG_W-1:0] hdg_in,
  input  logic [HDG_W-1:0] ofs_in,
  input  logic             sub_sel,
  output logic [HDG_W-1:0] hdg_out,
  output logic             hdg_ok
);
  logic [HDG_W-1:0] corr_c;
  logic             win_c;
  gyro_hdg_pkg::corr_dir_e dir_c;

  assign dir_c = gyro_hdg_pkg::corr_dir_e'(sub_sel);

  hdg_offset_alu #(.HDG_W(HDG_W)) u_alu (
    .hdg(hdg_in), .ofs(ofs_in), .dir(dir_c), .res(corr_c)
  );

  // Window check on the pre-register value so flag and heading land together.
  hdg_window_cmp #(.HDG_W(HDG_W), .RANGE_MIN(RANGE_MIN), .RANGE_MAX(RANGE_MAX)) u_win (
    .val(corr_c), .in_win(win_c)
  );

  hdg_out_reg #(.HDG_W(HDG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .d_val(corr_c), .d_ok(win_c),
    .q_val(hdg_out), .q_ok(hdg_ok)
  );
endmodule

// File: rtl/gyro_hdg_corr_chk.sv
module gyro_hdg_corr_chk #(
  parameter int HDG_W     = 12,
  parameter int RANGE_MIN = 16,
  parameter int RANGE_MAX = 4079
) (
  input logic             clk,
  input logic             rst_n,
  input logic [HDG_W-1:0] hdg_in,
  input logic [HDG_W-1:0] ofs_in,
  input logic             sub_sel,
  input logic [HDG_W-1:0] hdg_out,
  input logic             hdg_ok
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (hdg_out == '0 && !hdg_ok));
  // R2
  add_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sub_sel)) |-> hdg_out == HDG_W'($past(hdg_in) + $past(ofs_in)));
  // R3
  sub_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sub_sel)) |-> hdg_out == HDG_W'($past(hdg_in) - $past(ofs_in)));
  // R5
  window_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hdg_ok == (int'(hdg_out) >= RANGE_MIN && int'(hdg_out) <= RANGE_MAX));
endmodule

bind gyro_hdg_corr gyro_hdg_corr_chk #(.HDG_W(HDG_W), .RANGE_MIN(RANGE_MIN), .RANGE_MAX(RANGE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdg_in(hdg_in), .ofs_in(ofs_in),
  .sub_sel(sub_sel), .hdg_out(hdg_out), .hdg_ok(hdg_ok)
);

// File: tb/gyro_hdg_corr_tb.sv
module gyro_hdg_corr_tb;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] hdg_in = '0, ofs_in = '0;
  logic sub_sel = 1'b0;
  logic [W-1:0] hdg_out;
  logic hdg_ok;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  gyro_hdg_corr u_dut (
    .clk(clk), .rst_n(rst_n), .hdg_in(hdg_in), .ofs_in(ofs_in),
    .sub_sel(sub_sel), .hdg_out(hdg_out), .hdg_ok(hdg_ok)
  );

  // {hdg, ofs, sub, expected out, expected ok}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {12'd100,  12'd50,   1'b0, 12'd150,  1'b1},
    {12'd100,  12'd50,   1'b1, 12'd50,   1'b1},
    {12'd4090, 12'd10,   1'b0, 12'd4,    1'b0},  // R4 over top
    {12'd5,    12'd10,   1'b1, 12'd4091, 1'b0},  // R4 below zero
    {12'd4000, 12'd79,   1'b0, 12'd4079, 1'b1},  // R6 upper edge
    {12'd4000, 12'd80,   1'b0, 12'd4080, 1'b0},  // R6 just above
    {12'd30,   12'd14,   1'b1, 12'd16,   1'b1},  // R6 lower edge
    {12'd30,   12'd15,   1'b1, 12'd15,   1'b0},  // R6 just below
    {12'd0,    12'd0,    1'b0, 12'd0,    1'b0},
    {12'd2048, 12'd2048, 1'b1, 12'd0,    1'b0},
    {12'd4095, 12'd4095, 1'b0, 12'd4094, 1'b0},
    {12'd1000, 12'd0,    1'b1, 12'd1000, 1'b1},
    {12'd4090, 12'd22,   1'b0, 12'd16,   1'b1},  // R4 wrap onto lower bound
    {12'd10,   12'd27,   1'b1, 12'd4079, 1'b1}   // R4 wrap onto upper bound
  };

  task automatic chk(input string req, input logic [W-1:0] got_v, input logic got_k,
                     input logic [W-1:0] exp_v, input logic exp_k);
    checks++;
    if (got_v !== exp_v || got_k !== exp_k) begin
      errors++;
      $display("FAIL %s: got out=%0d ok=%0b expected out=%0d ok=%0b", req, got_v, got_k, exp_v, exp_k);
    end
  endtask

  task automatic apply(input logic [W-1:0] h, input logic [W-1:0] o, input logic s);
    @(negedge clk);
    hdg_in = h; ofs_in = o; sub_sel = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", hdg_out, hdg_ok, 12'd0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:26], VEC[i][25:14], VEC[i][13]);
      chk(VEC[i][13] ? "R3/R5 sub vector" : "R2/R5 add vector",
          hdg_out, hdg_ok, VEC[i][12:1], VEC[i][0]);
    end

    // R7: output holds until the next rising edge, then takes the new value
    apply(12'd200, 12'd100, 1'b0);
    hdg_in = 12'd500; ofs_in = 12'd1; sub_sel = 1'b1;
    #1;
    chk("R7 hold before edge", hdg_out, hdg_ok, 12'd300, 1'b1);
    @(negedge clk);
    chk("R7 update after edge", hdg_out, hdg_ok, 12'd499, 1'b1);

    // R1: asynchronous reset mid-run clears outputs at once
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear", hdg_out, hdg_ok, 12'd0, 1'b0);
    @(negedge clk);
    chk("R1 held in reset", hdg_out, hdg_ok, 12'd0, 1'b0);
    rst_n = 1'b1;
    apply(12'd4095, 12'd1, 1'b0);
    chk("R4 top wrap to zero", hdg_out, hdg_ok, 12'd0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule